// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Field-Masked Alarm

This block keeps calendar time as six BCD byte fields: seconds, minutes, hours, day of month, month and a two-digit year standing for 2000 to 2099. Time moves forward by one second on each clock cycle in which the one-second strobe input is high, provided the control register allows counting. A byte-wide register bus with a combinational read path gives software access to every field. Software reads the six time fields as separate bytes. If the seconds value it reads is zero, a carry may have rippled through the other fields between its reads, so it reads the whole set again.

An alarm unit holds a second set of six BCD fields and one enable bit for each field. On each second that the time advances, every enabled alarm field is compared with the updated time, and fields whose enable bit is clear are ignored. A match sets a sticky pending bit, but only while the global alarm enable is on. The interrupt output is the pending bit gated by that same global enable. Software clears the pending bit by writing a one to it.

Register map (address: content): 0 control (bit 0 run, bit 1 counter-select test, bit 2 clock-reset test); 1..6 time seconds, minutes, hours, date, month, year; 7 alarm control (bits 0..5 field enables in the same field order, bit 6 global enable); 8..13 alarm fields in the same order; 14 pending (bit 0 alarm). Unused bits read as zero.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the control, alarm control and pending registers read 0, the time reads 00:00:00 on date 01, month 01, year 00, and irq_o is 0. Reads are combinational from addr_i.
- R2: While control bit 0 (run) is 0, writes to addresses 1..6 load the time fields, and strobes do not change the time.
- R3: While run is 1, writes to addresses 1..6 are ignored.
- R4: The time advances only when run is 1 and control bits 1 and 2 are both 0. If either test bit is 1, strobes are ignored.
- R5: Each clock cycle with sec_pulse_i high and counting allowed adds one to the seconds in BCD (for example 09 becomes 10), and the new value can be read after that clock edge.
- R6: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into the date. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: The date wraps to 01 and carries into the month after the last day of the month: 30 for months 04, 06, 09 and 11; 31 for the other months except 02; and for month 02, 29 when the binary value of the year is divisible by 4, otherwise 28.
- R8: On a second that advances the time, if every alarm field whose enable bit (alarm control bits 0..5) is set equals the updated time field, the pending bit is set on the following clock edge. Disabled fields are not compared, and with no field enabled every advance matches.
- R9: A match sets the pending bit only while alarm control bit 6 (global enable) is 1. irq_o is 1 exactly when the pending bit and the global enable are both 1.
- R10: Writing address 14 with bit 0 set clears the pending bit. Writing it with bit 0 clear has no effect.
- R11: If a match sets the pending bit in the same cycle that a clear is written, the pending bit ends up 1.
- R12: Comparison happens only once per advance, so a time that still matches does not set the pending bit again without another advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_pulse_i | input | 1 | One-second strobe, one clock cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Two events can fall in the same cycle: an alarm match that sets the pending bit, and a software write that clears it. The bench arranges this by writing the clear one cycle after the advancing strobe, so the write lands on the edge where the match is registered. The pending bit must read 1 afterwards. A second case checks that the clear alone, with no new advance, still empties the bit, and that the comparison does not set it again while the time keeps matching.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NF       = 6;  // sec, min, hour, date, month, year
  localparam int A_CTRL   = 0;
  localparam int A_TIME0  = 1;
  localparam int A_ACTRL  = 7;
  localparam int A_ALM0   = 8;
  localparam int A_PEND   = 14;
  localparam int B_RUN    = 0;
  localparam int B_CSEL   = 1;
  localparam int B_CRST   = 2;
  localparam int B_GLOB   = 6;

  typedef logic [7:0] bcd_t;

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic bcd_t month_last(input bcd_t mon, input bcd_t yr);
    logic [6:0] yb;
    yb = 7'({3'b0, yr[7:4]} * 7'd10) + {3'b0, yr[3:0]};
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic [NF-1:0]        wr_i,
  input  logic [7:0]           wdata_i,
  output logic [NF-1:0][7:0]   t_o
);
  logic [NF-1:0][7:0] t_q, t_d, lim, wrapv;
  logic [NF:0]        carry;

  always_comb begin
    lim[0] = 8'h59; wrapv[0] = 8'h00;
    lim[1] = 8'h59; wrapv[1] = 8'h00;
    lim[2] = 8'h23; wrapv[2] = 8'h00;
    lim[3] = month_last(t_q[4], t_q[5]); wrapv[3] = 8'h01;
    lim[4] = 8'h12; wrapv[4] = 8'h01;
    lim[5] = 8'h99; wrapv[5] = 8'h00;
    carry[0] = adv_i;
    for (int i = 0; i < NF; i++) begin
      t_d[i] = t_q[i];
      if (wr_i[i])       t_d[i] = wdata_i;
      else if (carry[i]) t_d[i] = (t_q[i] == lim[i]) ? wrapv[i] : bcd_inc(t_q[i]);
      carry[i+1] = carry[i] && (t_q[i] == lim[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q    <= '0;
      t_q[3] <= 8'h01;
      t_q[4] <= 8'h01;
    end else begin
      t_q <= t_d;
    end
  end

  assign t_o = t_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NF-1:0][7:0] cur_i,
  input  logic [NF-1:0][7:0] alm_i,
  input  logic [NF-1:0]      fld_en_i,
  input  logic               glob_i,
  input  logic               tick_i,
  input  logic               clr_i,
  output logic               pend_o
);
  logic [NF-1:0] hit;
  logic          set_w;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign hit[g] = !fld_en_i[g] || (cur_i[g] == alm_i[g]);
  end

  assign set_w = tick_i && glob_i && (&hit);

  // set takes priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= set_w || (pend_o && !clr_i);
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_pulse_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  logic [2:0]         ctrl_q;
  logic [6:0]         actrl_q;
  logic [NF-1:0][7:0] alm_q, tm;
  logic [NF-1:0]      time_wr;
  logic               run_ok, adv, tick_q, clr, pend;
  logic [7:0]         sec_w;

  assign run_ok = ctrl_q[B_RUN] && !ctrl_q[B_CSEL] && !ctrl_q[B_CRST];
  assign adv    = sec_pulse_i && run_ok;
  assign clr    = we_i && (addr_i == ADDR_W'(A_PEND)) && wdata_i[0];
  assign sec_w  = tm[0];

  for (genvar g = 0; g < NF; g++) begin : g_twr
    assign time_wr[g] = we_i && !ctrl_q[B_RUN] && (addr_i == ADDR_W'(A_TIME0 + g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      actrl_q <= '0;
      alm_q   <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= adv;
      if (we_i) begin
        if (addr_i == ADDR_W'(A_CTRL))  ctrl_q  <= wdata_i[2:0];
        if (addr_i == ADDR_W'(A_ACTRL)) actrl_q <= wdata_i[6:0];
        for (int i = 0; i < NF; i++)
          if (addr_i == ADDR_W'(A_ALM0 + i)) alm_q[i] <= wdata_i;
      end
    end
  end

  rtc_calendar i_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .wr_i    (time_wr),
    .wdata_i (wdata_i),
    .t_o     (tm)
  );

  rtc_alarm i_alm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_i    (tm),
    .alm_i    (alm_q),
    .fld_en_i (actrl_q[NF-1:0]),
    .glob_i   (actrl_q[B_GLOB]),
    .tick_i   (tick_q),
    .clr_i    (clr),
    .pend_o   (pend)
  );

  assign irq_o = pend && actrl_q[B_GLOB];

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == ADDR_W'(A_CTRL))  rdata_o = {5'b0, ctrl_q};
    if (addr_i == ADDR_W'(A_ACTRL)) rdata_o = {1'b0, actrl_q};
    if (addr_i == ADDR_W'(A_PEND))  rdata_o = {7'b0, pend};
    for (int i = 0; i < NF; i++) begin
      if (addr_i == ADDR_W'(A_TIME0 + i)) rdata_o = tm[i];
      if (addr_i == ADDR_W'(A_ALM0 + i))  rdata_o = alm_q[i];
    end
  end
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sec_pulse_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              irq_o,
  input logic              run_ok,
  input logic              tick_q,
  input logic              pend,
  input logic              glob,
  input logic [7:0]        sec_w
);
  // R2
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sec_pulse_i && run_ok) && !(we_i && addr_i == ADDR_W'(rtc_pkg::A_TIME0)) |=> $stable(sec_w));

  // R6
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_i && run_ok && sec_w == 8'h59) |=> (sec_w == 8'h00));

  // R8
  pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend) |-> ($past(tick_q) && $past(glob)));

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (glob && pend));

  // R10
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(rtc_pkg::A_PEND) && wdata_i[0] && !tick_q) |=> !pend);
endmodule

bind bcd_rtc rtc_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sec_pulse_i (sec_pulse_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .irq_o       (irq_o),
  .run_ok      (run_ok),
  .tick_q      (tick_q),
  .pend        (pend),
  .glob        (actrl_q[6]),
  .sec_w       (sec_w)
);

// File: tb/test_bcd_rtc.sv
module test_bcd_rtc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sec_pulse_i = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_rtc #(.ADDR_W(4)) i_bcd_rtc (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_pulse_i(sec_pulse_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i); sec_pulse_i = 1'b1;
    @(negedge clk_i); sec_pulse_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dt, mo, y);
    wr(4'd0, 8'h00);
    wr(4'd1, s); wr(4'd2, mi); wr(4'd3, h);
    wr(4'd4, dt); wr(4'd5, mo); wr(4'd6, y);
    wr(4'd0, 8'h01);
  endtask

  task automatic expect_date(input string req, input logic [7:0] dt, mo, y);
    logic [7:0] d;
    rd(4'd4, d); chk(req, d, dt);
    rd(4'd5, d); chk(req, d, mo);
    rd(4'd6, d); chk(req, d, y);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd0, d);  chk("R1 ctrl", d, 8'h00);
    rd(4'd7, d);  chk("R1 actrl", d, 8'h00);
    rd(4'd14, d); chk("R1 pend", d, 8'h00);
    rd(4'd1, d);  chk("R1 sec", d, 8'h00);
    rd(4'd3, d);  chk("R1 hour", d, 8'h00);
    expect_date("R1", 8'h01, 8'h01, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_stopped();
    logic [7:0] d;
    wr(4'd1, 8'h30);
    rd(4'd1, d); chk("R2 write stopped", d, 8'h30);
    tick();
    rd(4'd1, d); chk("R2 no advance", d, 8'h30);
  endtask

  task automatic t_running_write();
    logic [7:0] d;
    wr(4'd0, 8'h01);
    wr(4'd1, 8'h45);
    rd(4'd1, d); chk("R3 write ignored", d, 8'h30);
  endtask

  task automatic t_test_bits();
    logic [7:0] d;
    wr(4'd0, 8'h03); tick();
    rd(4'd1, d); chk("R4 csel blocks", d, 8'h30);
    wr(4'd0, 8'h05); tick();
    rd(4'd1, d); chk("R4 crst blocks", d, 8'h30);
  endtask

  task automatic t_bcd_inc();
    logic [7:0] d;
    set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    tick();
    rd(4'd1, d); chk("R5 09->10", d, 8'h10);
    tick();
    rd(4'd1, d); chk("R5 10->11", d, 8'h11);
  endtask

  task automatic t_ripple();
    logic [7:0] d;
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    tick();
    rd(4'd1, d); chk("R6 sec", d, 8'h00);
    rd(4'd2, d); chk("R6 min", d, 8'h00);
    rd(4'd3, d); chk("R6 hour", d, 8'h00);
    expect_date("R6 year wrap", 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
    tick(); expect_date("R7 leap 28", 8'h29, 8'h02, 8'h24);
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24);
    tick(); expect_date("R7 leap 29", 8'h01, 8'h03, 8'h24);
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
    tick(); expect_date("R7 plain feb", 8'h01, 8'h03, 8'h23);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23);
    tick(); expect_date("R7 april", 8'h01, 8'h05, 8'h23);
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h23);
    tick(); expect_date("R7 may 30", 8'h31, 8'h05, 8'h23);
  endtask

  task automatic t_alarm_mask();
    logic [7:0] d;
    wr(4'd8, 8'h05); wr(4'd9, 8'h33);
    wr(4'd7, 8'h41);
    set_time(8'h04, 8'h10, 8'h07, 8'h02, 8'h03, 8'h11);
    tick();
    rd(4'd14, d); chk("R8 masked match", d, 8'h01);
    chk("R9 irq on", {7'b0, irq_o}, 8'h01);
    wr(4'd14, 8'h01);
    rd(4'd14, d); chk("R10 clear", d, 8'h00);
    wr(4'd7, 8'h43);
    set_time(8'h04, 8'h10, 8'h07, 8'h02, 8'h03, 8'h11);
    tick();
    rd(4'd14, d); chk("R8 min mismatch", d, 8'h00);
  endtask

  task automatic t_glob();
    logic [7:0] d;
    wr(4'd7, 8'h01);
    set_time(8'h04, 8'h10, 8'h07, 8'h02, 8'h03, 8'h11);
    tick();
    rd(4'd14, d); chk("R9 no glob no pend", d, 8'h00);
    chk("R9 irq off", {7'b0, irq_o}, 8'h00);
    wr(4'd7, 8'h41);
    set_time(8'h04, 8'h10, 8'h07, 8'h02, 8'h03, 8'h11);
    tick();
    wr(4'd7, 8'h01);
    rd(4'd14, d); chk("R9 pend kept", d, 8'h01);
    chk("R9 irq gated", {7'b0, irq_o}, 8'h00);
    wr(4'd14, 8'h00);
    rd(4'd14, d); chk("R10 zero write", d, 8'h01);
    wr(4'd7, 8'h41);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    set_time(8'h04, 8'h10, 8'h07, 8'h02, 8'h03, 8'h11);
    @(negedge clk_i); sec_pulse_i = 1'b1;
    @(negedge clk_i); sec_pulse_i = 1'b0;
    addr_i = 4'd14; wdata_i = 8'h01; we_i = 1'b1;
    @(negedge clk_i); we_i = 1'b0;
    rd(4'd14, d); chk("R11 set beats clear", d, 8'h01);
    wr(4'd14, 8'h01);
    repeat (5) @(negedge clk_i);
    rd(4'd14, d); chk("R12 no rematch", d, 8'h00);
    rd(4'd1, d);  chk("R12 time still matches", d, 8'h05);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_stopped();
    t_running_write();
    t_test_bits();
    t_bcd_inc();
    t_ripple();
    t_months();
    t_alarm_mask();
    t_glob();
    t_collide();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule